// File: doc/BRIEF.md
# Adaptive Resonant Frequency Sweep Controller

This block keeps a 16-bit control word that takes the place of an oscillator control voltage in a resonant lamp ballast. A word of zero selects the highest switching frequency. The largest word selects the programmed minimum frequency. The block also runs the ballast mode sequence. After power-up it waits in supply lockout. Once the supply is good it sweeps the frequency down through resonance, and after ignition it settles in run mode. In run mode it keeps zero-voltage switching by nudging the frequency back up whenever a hard-switching event is flagged. It latches off into a fault when protection trips.

Two supply comparator flags feed the block: supply above the rising level, and supply below the falling level. It also takes a per-cycle strobe marking the low-side turn-on instant, a non-zero-voltage-switching flag that is valid with that strobe, and a crest-factor fault flag. It drives the control word, the current mode, a gate enable for the half-bridge driver, and enables for the ZVS correction and crest-factor protection logic. Word changes happen on a tick derived from the clock by a parameterised divider.

The modes are LOCKOUT, SWEEP, RUN and FAULT. The transitions are named as follows:
- POWER_GOOD: LOCKOUT to SWEEP when the supply is above the rising level.
- IGNITED: SWEEP to RUN when the word passes the run level.
- SHUTDOWN: RUN to FAULT when the word falls below the floor or a crest fault is flagged.
- BROWNOUT: any mode to LOCKOUT when the supply falls below the falling level.

Top module: `ballast_sweep_ctrl`

## Requirements
- R1: After reset the mode is LOCKOUT, the control word is 0 and all enables are 0. LOCKOUT holds the word at 0 and stays in place until `supply_above_hi` is 1, which moves the block to SWEEP on the next clock edge (POWER_GOOD).
- R2: In SWEEP, on each tick the word grows by QS_STEP (default 500) while it is below QS_LEVEL (default 8500), and by SWEEP_STEP (default 100) once it is at or above that level.
- R3: The word never exceeds WORD_MAX (default 60000, the minimum-frequency setting). An increment that would pass it clamps to WORD_MAX.
- R4: SWEEP moves to RUN on the edge after the word is strictly greater than RUN_LEVEL (default 48000) (IGNITED). In SWEEP, the non-ZVS strobe and the crest fault flag have no effect on the word or the mode.
- R5: In RUN, a cycle with `lo_turn_on` and `nzvs_flag` both 1 lowers the word by NZVS_STEP (default 800), flooring at 0. This decrement takes precedence over a tick in the same cycle. A strobe with `nzvs_flag` 0 changes nothing, and ticks keep adding SWEEP_STEP.
- R6: In RUN, a word strictly below FLOOR_LEVEL (default 8200), or `crest_fault` at 1, moves the block to FAULT on the next edge (SHUTDOWN). In FAULT, `gate_en` is 0 and the word is forced to 0 one cycle later.
- R7: FAULT ignores `supply_above_hi`, the non-ZVS strobe and the crest flag. It is left only through LOCKOUT, via BROWNOUT followed by POWER_GOOD.
- R8: `supply_below_lo` at 1 sends any mode to LOCKOUT on the next edge (BROWNOUT). It has priority over every other input, including `supply_above_hi`.
- R9: `mode` encodes LOCKOUT=0, SWEEP=1, RUN=2, FAULT=3. `gate_en` is 1 in SWEEP and RUN. `zvs_en` and `crest_en` are 1 only in RUN.
- R10: A tick occurs once every TICK_DIV clocks (default 4), counted from reset release. The first tick falls on the TICK_DIV-th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_above_hi | input | 1 | Supply is above the rising threshold |
| supply_below_lo | input | 1 | Supply is below the falling threshold |
| lo_turn_on | input | 1 | One-cycle strobe at the low-side turn-on instant |
| nzvs_flag | input | 1 | Non-zero-voltage switching seen at that turn-on |
| crest_fault | input | 1 | Peak-to-average current fault flag |
| ctrl_word | output | 16 | Oscillator control word (0 = highest frequency) |
| mode | output | 2 | Current mode, encoded as in R9 |
| gate_en | output | 1 | Half-bridge gate drive permitted |
| zvs_en | output | 1 | ZVS correction enabled |
| crest_en | output | 1 | Crest-factor protection enabled |

## Verification
Several properties are checked on every clock: the word ceiling, the exact quick-start and ZVS step sizes, the zero word in LOCKOUT and FAULT, BROWNOUT priority, the stickiness of FAULT, and the IGNITED and crest SHUTDOWN transitions. The remaining behaviour needs scenarios from the bench:
- the handover from fast to slow ramp at exactly 8500 then 8600;
- the decrement winning over a coincident tick;
- the floor-driven shutdown after repeated hard-switching events;
- the full FAULT-to-LOCKOUT-to-SWEEP recovery;
- random non-ZVS and crest activity being ignored during the sweep.

// File: rtl/ballast_pkg.sv
package ballast_pkg;

    typedef enum logic [1:0] {
        MODE_LOCK  = 2'd0,
        MODE_SWEEP = 2'd1,
        MODE_RUN   = 2'd2,
        MODE_FAULT = 2'd3
    } bmode_t;

endpackage

// File: rtl/sweep_tick.sv
module sweep_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = (cnt_q == LAST);

            AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LAST);  // R10
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);  // R10
        end
    endgenerate

endmodule

// File: rtl/ctrl_word_ramp.sv
module ctrl_word_ramp
    import ballast_pkg::*;
#(
    parameter int                WORD_W     = 16,
    parameter logic [WORD_W-1:0] WORD_MAX   = 16'd60000,
    parameter logic [WORD_W-1:0] QS_LEVEL   = 16'd8500,
    parameter logic [WORD_W-1:0] QS_STEP    = 16'd500,
    parameter logic [WORD_W-1:0] SWEEP_STEP = 16'd100,
    parameter logic [WORD_W-1:0] NZVS_STEP  = 16'd800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  bmode_t            mode_i,
    input  logic              lo_strobe_i,
    input  logic              nzvs_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] word_q, word_d;
    logic [WORD_W-1:0] up_step;
    logic [WORD_W:0]   up_sum;
    logic [WORD_W-1:0] up_sat;
    logic [WORD_W-1:0] down_val;
    logic              nzvs_hit;

    assign nzvs_hit = lo_strobe_i && nzvs_i;

    always_comb begin
        if (mode_i == MODE_SWEEP && word_q < QS_LEVEL) up_step = QS_STEP;
        else                                          up_step = SWEEP_STEP;
        up_sum   = {1'b0, word_q} + {1'b0, up_step};
        up_sat   = (up_sum > {1'b0, WORD_MAX}) ? WORD_MAX : up_sum[WORD_W-1:0];
        down_val = (word_q >= NZVS_STEP) ? (word_q - NZVS_STEP) : '0;
    end

    always_comb begin
        word_d = word_q;
        unique case (mode_i)
            MODE_LOCK, MODE_FAULT: word_d = '0;
            MODE_SWEEP: if (tick_i) word_d = up_sat;
            MODE_RUN: begin
                if (nzvs_hit)    word_d = down_val;
                else if (tick_i) word_d = up_sat;
            end
            default: word_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        word_q <= WORD_MAX);  // R3
    AST_QS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SWEEP && tick_i && word_q < QS_LEVEL && word_q <= WORD_MAX - QS_STEP)
        |=> word_q == $past(word_q) + QS_STEP);  // R2
    AST_SWEEP_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SWEEP && $past(mode_i) == MODE_SWEEP) |-> word_q >= $past(word_q));  // R2
    AST_NZVS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RUN && lo_strobe_i && nzvs_i && word_q >= NZVS_STEP)
        |=> word_q == $past(word_q) - NZVS_STEP);  // R5
    AST_LOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_LOCK && $past(mode_i) == MODE_LOCK) |-> word_q == '0);  // R1
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_FAULT && $past(mode_i) == MODE_FAULT) |-> word_q == '0);  // R6

endmodule

// File: rtl/ballast_mode_fsm.sv
module ballast_mode_fsm
    import ballast_pkg::*;
#(
    parameter int                WORD_W      = 16,
    parameter logic [WORD_W-1:0] RUN_LEVEL   = 16'd48000,
    parameter logic [WORD_W-1:0] FLOOR_LEVEL = 16'd8200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_hi_i,
    input  logic              supply_lo_i,
    input  logic              crest_i,
    input  logic [WORD_W-1:0] word_i,
    output bmode_t            mode_o,
    output logic              gate_en_o,
    output logic              zvs_en_o,
    output logic              crest_en_o
);

    bmode_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (supply_lo_i) begin
            state_d = MODE_LOCK;
        end else begin
            unique case (state_q)
                MODE_LOCK:  if (supply_hi_i)          state_d = MODE_SWEEP;
                MODE_SWEEP: if (word_i > RUN_LEVEL)   state_d = MODE_RUN;
                MODE_RUN:   if (word_i < FLOOR_LEVEL || crest_i) state_d = MODE_FAULT;
                MODE_FAULT: state_d = MODE_FAULT;
                default:    state_d = MODE_LOCK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_LOCK;
        else        state_q <= state_d;
    end

    always_comb begin
        gate_en_o  = 1'b0;
        zvs_en_o   = 1'b0;
        crest_en_o = 1'b0;
        unique case (state_q)
            MODE_LOCK, MODE_FAULT: ;
            MODE_SWEEP: gate_en_o = 1'b1;
            MODE_RUN: begin
                gate_en_o  = 1'b1;
                zvs_en_o   = 1'b1;
                crest_en_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign mode_o = state_q;

    AST_BROWNOUT: assert property (@(posedge clk) disable iff (!rst_n)
        supply_lo_i |=> state_q == MODE_LOCK);  // R8
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_LOCK && !supply_hi_i) |=> state_q == MODE_LOCK);  // R1
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_FAULT && !supply_lo_i) |=> state_q == MODE_FAULT);  // R7
    AST_IGNITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_SWEEP && !supply_lo_i && word_i > RUN_LEVEL) |=> state_q == MODE_RUN);  // R4
    AST_CREST_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_RUN && !supply_lo_i && crest_i) |=> state_q == MODE_FAULT);  // R6

endmodule

// File: rtl/ballast_sweep_ctrl.sv
module ballast_sweep_ctrl
    import ballast_pkg::*;
#(
    parameter int                WORD_W      = 16,
    parameter int                TICK_DIV    = 4,
    parameter logic [WORD_W-1:0] WORD_MAX    = 16'd60000,
    parameter logic [WORD_W-1:0] QS_LEVEL    = 16'd8500,
    parameter logic [WORD_W-1:0] RUN_LEVEL   = 16'd48000,
    parameter logic [WORD_W-1:0] FLOOR_LEVEL = 16'd8200,
    parameter logic [WORD_W-1:0] QS_STEP     = 16'd500,
    parameter logic [WORD_W-1:0] SWEEP_STEP  = 16'd100,
    parameter logic [WORD_W-1:0] NZVS_STEP   = 16'd800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_above_hi,
    input  logic              supply_below_lo,
    input  logic              lo_turn_on,
    input  logic              nzvs_flag,
    input  logic              crest_fault,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [1:0]        mode,
    output logic              gate_en,
    output logic              zvs_en,
    output logic              crest_en
);

    logic   tick;
    bmode_t cur_mode;

    sweep_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    ctrl_word_ramp #(
        .WORD_W     (WORD_W),
        .WORD_MAX   (WORD_MAX),
        .QS_LEVEL   (QS_LEVEL),
        .QS_STEP    (QS_STEP),
        .SWEEP_STEP (SWEEP_STEP),
        .NZVS_STEP  (NZVS_STEP)
    ) u_ramp (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .mode_i      (cur_mode),
        .lo_strobe_i (lo_turn_on),
        .nzvs_i      (nzvs_flag),
        .word_o      (ctrl_word)
    );

    ballast_mode_fsm #(
        .WORD_W      (WORD_W),
        .RUN_LEVEL   (RUN_LEVEL),
        .FLOOR_LEVEL (FLOOR_LEVEL)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_hi_i (supply_above_hi),
        .supply_lo_i (supply_below_lo),
        .crest_i     (crest_fault),
        .word_i      (ctrl_word),
        .mode_o      (cur_mode),
        .gate_en_o   (gate_en),
        .zvs_en_o    (zvs_en),
        .crest_en_o  (crest_en)
    );

    assign mode = cur_mode;

    AST_PROT_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (zvs_en || crest_en) |-> gate_en);  // R9
    AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode == 2'd3) |-> !gate_en && !zvs_en);  // R6

endmodule

// File: tb/ballast_sweep_ctrl_test.sv
`timescale 1ns/1ps
module ballast_sweep_ctrl_test;

    localparam int TICK_DIV    = 4;
    localparam int WORD_MAX    = 60000;
    localparam int QS_LEVEL    = 8500;
    localparam int RUN_LEVEL   = 48000;
    localparam int FLOOR_LEVEL = 8200;
    localparam int QS_STEP     = 500;
    localparam int SWEEP_STEP  = 100;
    localparam int NZVS_STEP   = 800;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hi, lo, str, nz, cr;
    logic [15:0] word;
    logic [1:0]  mode;
    logic        gate_en, zvs_en, crest_en;

    always #2.5 clk = ~clk;

    ballast_sweep_ctrl #(
        .WORD_W(16), .TICK_DIV(TICK_DIV), .WORD_MAX(16'(WORD_MAX)), .QS_LEVEL(16'(QS_LEVEL)),
        .RUN_LEVEL(16'(RUN_LEVEL)), .FLOOR_LEVEL(16'(FLOOR_LEVEL)), .QS_STEP(16'(QS_STEP)),
        .SWEEP_STEP(16'(SWEEP_STEP)), .NZVS_STEP(16'(NZVS_STEP))
    ) uut (
        .clk(clk), .rst_n(rst_n), .supply_above_hi(hi), .supply_below_lo(lo),
        .lo_turn_on(str), .nzvs_flag(nz), .crest_fault(cr), .ctrl_word(word),
        .mode(mode), .gate_en(gate_en), .zvs_en(zvs_en), .crest_en(crest_en)
    );

    int    total = 0;
    int    bad   = 0;
    bit    cmp_on = 0;
    bit    done   = 0;
    string cur_req = "R1";

    int m_word, m_mode, m_cnt;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat_up(input int w, input int st);
        return (w + st > WORD_MAX) ? WORD_MAX : w + st;
    endfunction

    function automatic int next_word(input int md, input int w, input bit tk, input bit hit);
        case (md)
            1: return tk ? sat_up(w, (w < QS_LEVEL) ? QS_STEP : SWEEP_STEP) : w;
            2: if (hit) return (w >= NZVS_STEP) ? w - NZVS_STEP : 0;
               else return tk ? sat_up(w, SWEEP_STEP) : w;
            default: return 0;
        endcase
    endfunction

    function automatic int next_mode(input int md, input int w, input bit h, input bit l, input bit c);
        if (l) return 0;
        case (md)
            0: return h ? 1 : 0;
            1: return (w > RUN_LEVEL) ? 2 : 1;
            2: return (w < FLOOR_LEVEL || c) ? 3 : 2;
            default: return 3;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = 0; m_mode = 0; m_cnt = 0;
        end else begin
            int  nw, nm;
            bit  tk;
            tk = (m_cnt == TICK_DIV - 1);
            nw = next_word(m_mode, m_word, tk, str && nz);
            nm = next_mode(m_mode, m_word, hi, lo, cr);
            m_word = nw; m_mode = nm;
            m_cnt = tk ? 0 : m_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(word == 16'(m_word), cur_req, "word", word, m_word);
            chk(mode == 2'(m_mode), cur_req, "mode", mode, m_mode);
            chk(gate_en == (m_mode == 1 || m_mode == 2), "R9", "gate_en", gate_en, m_mode == 1 || m_mode == 2);
            chk(zvs_en == (m_mode == 2) && crest_en == (m_mode == 2), "R9", "prot_en", zvs_en, m_mode == 2);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    task automatic reach_mode(input int target, input bit rnd, input string req);
        int prev;
        int n;
        n = 0; prev = word;
        while (mode != 2'(target) && n < 5000) begin
            if (rnd) begin
                str = 1'($urandom % 2); nz = 1'($urandom % 2);
                cr = (m_word <= RUN_LEVEL) ? 1'($urandom % 8 == 0) : 1'b0;
            end
            prev = word;
            @(negedge clk);
            n++;
        end
        str = 0; nz = 0; cr = 0;
        chk(mode == 2'(target), req, "mode reached", mode, target);
        if (target == 2) chk(prev > RUN_LEVEL, "R4", "word before run", prev, RUN_LEVEL + 1);
        if (target == 3) chk(prev < FLOOR_LEVEL, "R6", "word before fault", prev, FLOOR_LEVEL - 1);
    endtask

    initial begin
        int w0, n;
        void'($urandom(32'd31337));
        rst_n = 0; hi = 0; lo = 0; str = 0; nz = 0; cr = 0;
        repeat (3) @(negedge clk);
        chk(word == 0, "R1", "reset word", word, 0);
        chk(mode == 0, "R9", "reset mode", mode, 0);
        chk(!gate_en && !zvs_en && !crest_en, "R1", "reset enables", gate_en, 0);
        rst_n = 1; cmp_on = 1;

        // lockout holds without the rising-level flag; noise ignored
        cur_req = "R1";
        repeat (8) begin str = 1'($urandom % 2); nz = 1; cr = 1'($urandom % 2); @(negedge clk); end
        str = 0; nz = 0; cr = 0;
        chk(mode == 0 && word == 0, "R1", "lockout hold", mode, 0);
        hi = 1;
        @(negedge clk);
        chk(mode == 1, "R1", "power good", mode, 1);

        // quick-start to slow-ramp handover (tick phase per R10)
        cur_req = "R2";
        n = 0;
        while (word < QS_LEVEL && n < 500) begin
            str = 1'($urandom % 2); nz = 1'($urandom % 2); cr = 1'($urandom % 8 == 0);
            @(negedge clk); n++;
        end
        chk(word == QS_LEVEL, "R2", "quick-start end", word, QS_LEVEL);
        w0 = word; n = 0;
        while (word == 16'(w0) && n < 20) begin @(negedge clk); n++; end
        chk(word == QS_LEVEL + SWEEP_STEP, "R2", "first slow step", word, QS_LEVEL + SWEEP_STEP);
        chk(n <= TICK_DIV, "R10", "tick spacing", n, TICK_DIV);

        // random activity during sweep is ignored
        cur_req = "R4";
        reach_mode(2, 1, "R4");

        cur_req = "R3";
        n = 0;
        while (word != WORD_MAX && n < 2000) begin @(negedge clk); n++; end
        repeat (20) @(negedge clk);
        chk(word == WORD_MAX, "R3", "saturated word", word, WORD_MAX);

        // random non-ZVS events in run
        cur_req = "R5";
        repeat (300) begin
            str = 1'($urandom % 32 == 0); nz = 1'($urandom % 2);
            @(negedge clk);
        end
        str = 0; nz = 0;
        chk(mode == 2, "R5", "still running", mode, 2);
        // decrement coincident with a tick
        n = 0;
        while (m_cnt != TICK_DIV - 1 && n < 10) begin @(negedge clk); n++; end
        w0 = word; str = 1; nz = 1;
        @(negedge clk);
        str = 0; nz = 0;
        chk(word == 16'(w0 - NZVS_STEP), "R5", "decrement over tick", word, w0 - NZVS_STEP);
        // strobe without the flag, away from a tick
        n = 0;
        while (m_cnt != 0 && n < 10) begin @(negedge clk); n++; end
        w0 = word; str = 1; nz = 0;
        @(negedge clk);
        str = 0;
        chk(word == 16'(w0), "R5", "clean turn-on", word, w0);

        // crest fault shutdown
        cur_req = "R6";
        cr = 1;
        @(negedge clk);
        cr = 0;
        chk(mode == 3, "R6", "crest to fault", mode, 3);
        chk(!gate_en, "R6", "gates off", gate_en, 0);
        @(negedge clk);
        chk(word == 0, "R6", "fault word", word, 0);

        cur_req = "R7";
        repeat (20) begin
            str = 1'($urandom % 2); nz = 1'($urandom % 2); cr = 1'($urandom % 2);
            @(negedge clk);
        end
        str = 0; nz = 0; cr = 0;
        chk(mode == 3 && word == 0, "R7", "fault latched", mode, 3);
        lo = 1; hi = 0;
        @(negedge clk);
        lo = 0;
        chk(mode == 0, "R8", "brownout from fault", mode, 0);
        repeat (4) @(negedge clk);
        chk(mode == 0, "R7", "lockout waits", mode, 0);
        hi = 1;
        @(negedge clk);
        chk(mode == 1, "R7", "recovered to sweep", mode, 1);

        // floor-driven shutdown
        cur_req = "R4";
        reach_mode(2, 0, "R4");
        cur_req = "R6";
        str = 1; nz = 1;
        reach_mode(3, 0, "R6");

        // brownout during sweep, with both supply flags set
        cur_req = "R8";
        lo = 1; hi = 0;
        @(negedge clk);
        lo = 0; hi = 1;
        @(negedge clk);
        chk(mode == 1, "R8", "sweep again", mode, 1);
        repeat (100) @(negedge clk);
        lo = 1;
        @(negedge clk);
        lo = 0;
        chk(mode == 0, "R8", "brownout beats power good", mode, 0);
        hi = 0;
        @(negedge clk);
        chk(word == 0, "R8", "word cleared", word, 0);
        repeat (3) @(negedge clk);

        cmp_on = 0;
        finish_run();
    end

endmodule